// File: doc/BRIEF.md
# Channel and Reference Selection Lock Buffer

This block sits between the CPU-writable selection fields of an analog-to-digital converter and the control lines of its analog input multiplexer and reference switch. Software writes a channel code and a reference code into a shadow register, which it can read back at any time. A second register, the effective selection, drives the analog side. The effective selection follows the shadow register while no conversion is running.

When the conversion sequencer signals a start, the effective selection captures the shadow value at that edge and then holds it, so the sampling phase always sees a steady input. Writes made after the start land only in the shadow register. In the last converter clock cycle before the completion flag rises, the sequencer pulses a reopen indication. At that edge the effective selection picks up the shadow value again and resumes tracking, so a setting written during a conversion takes effect for the next conversion. Lowering the converter enable releases the lock at once.

Each cycle of `clk` is one converter clock cycle. The start and last-cycle indications are single-cycle pulses from the sequencer.

Top module: `mux_sel_lock`

## Requirements
- R1: `rd_data` always returns the shadow register, packed with the reference code in the upper REF_W bits and the channel code in the lower CH_W bits. A write with `cpu_wr_en` high is visible on `rd_data` after the clock edge that samples it.
- R2: While enabled and not locked, each clock edge loads the effective selection from the shadow value of that edge. A write therefore reaches `eff_chan`/`eff_ref` on the same edge as it reaches `rd_data`.
- R3: A `conv_start` pulse while `adc_en` is high makes the effective selection take the shadow value at that edge, including a write in the same cycle. The lock then engages.
- R4: While locked, writes change `rd_data` but leave `eff_chan` and `eff_ref` unchanged.
- R5: A `conv_last` pulse while locked loads the shadow value into the effective selection at that edge and releases the lock. Later writes are followed again.
- R6: When a new `conv_start` follows directly on the cycle after `conv_last` (free-running), a write made after that restart does not reach the effective selection until the restarted conversion's own `conv_last`.
- R7: While `adc_en` is low, the lock is released, `conv_start` is ignored, and the effective selection follows the shadow register on every edge.
- R8: If `conv_start` and `conv_last` arrive in the same cycle, the start prevails and the lock stays engaged.
- R9: After synchronous reset, the shadow and effective registers are all zero and the block is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_en | input | 1 | Converter enable; low forces tracking |
| cpu_wr_en | input | 1 | CPU write strobe for the selection fields |
| cpu_wr_data | input | CH_W+REF_W | Write data: {reference, channel} |
| conv_start | input | 1 | Conversion-start pulse from the sequencer |
| conv_last | input | 1 | Pulse in the last cycle before completion |
| rd_data | output | CH_W+REF_W | Readback of the shadow register |
| eff_chan | output | CH_W | Effective channel select to the multiplexer |
| eff_ref | output | REF_W | Effective reference select |

## Verification
The bench uses the default widths: a 5-bit channel and a 2-bit reference. With these widths an all-ones channel next to a distinct reference code shows whether the fields sit in the right place in the readback, and every field fits in a single write. The short conversion windows in the bench cover back-to-back restarts, a start and a last-cycle pulse in the same cycle, and a disable in the middle of a conversion, all within a few cycles of each other.

// File: rtl/mux_sel_lock_pkg.sv
package mux_sel_lock_pkg;

    parameter int DEF_CH_W  = 5;
    parameter int DEF_REF_W = 2;

    typedef enum logic {
        LK_TRACK  = 1'b0,
        LK_HOLD   = 1'b1
    } lock_state_e;

    // Next lock state from the sequencer events; start beats last.
    function automatic lock_state_e next_lock(
        input lock_state_e cur,
        input logic        en,
        input logic        start,
        input logic        last
    );
        lock_state_e nxt;
        if (!en)        nxt = LK_TRACK;
        else if (start) nxt = LK_HOLD;
        else if (last)  nxt = LK_TRACK;
        else            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/mux_sel_shadow.sv
module mux_sel_shadow #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] shadow_nxt
);

    always_comb begin
        shadow_nxt = wr_en ? wr_data : shadow_q;
    end

    always_ff @(posedge clk) begin
        if (rst) shadow_q <= '0;
        else     shadow_q <= shadow_nxt;
    end

endmodule

// File: rtl/mux_sel_lock_ctrl.sv
module mux_sel_lock_ctrl
    import mux_sel_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adc_en,
    input  logic conv_start,
    input  logic conv_last,
    output logic capture,
    output logic locked
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = next_lock(state_q, adc_en, conv_start, conv_last);
        // Load the effective copy whenever tracking, at a start, or at reopen.
        capture = !adc_en || (state_q == LK_TRACK) || conv_start || conv_last;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_TRACK;
        else     state_q <= state_d;
    end

    assign locked = (state_q == LK_HOLD);

endmodule

// File: rtl/mux_sel_eff_reg.sv
module mux_sel_eff_reg #(
    parameter int CH_W  = 5,
    parameter int REF_W = 2,
    localparam int W    = CH_W + REF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     sel_in,
    output logic [CH_W-1:0]  chan_q,
    output logic [REF_W-1:0] ref_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            ref_q  <= '0;
        end else if (load) begin
            chan_q <= sel_in[CH_W-1:0];
            ref_q  <= sel_in[W-1:CH_W];
        end
    end

endmodule

// File: rtl/mux_sel_lock.sv
module mux_sel_lock
    import mux_sel_lock_pkg::*;
#(
    parameter int CH_W  = DEF_CH_W,
    parameter int REF_W = DEF_REF_W,
    localparam int SEL_W = CH_W + REF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adc_en,
    input  logic             cpu_wr_en,
    input  logic [SEL_W-1:0] cpu_wr_data,
    input  logic             conv_start,
    input  logic             conv_last,
    output logic [SEL_W-1:0] rd_data,
    output logic [CH_W-1:0]  eff_chan,
    output logic [REF_W-1:0] eff_ref
);

    logic [SEL_W-1:0] shadow_q;
    logic [SEL_W-1:0] shadow_nxt;
    logic             capture;
    logic             lock_active;

    mux_sel_shadow #(.W(SEL_W)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cpu_wr_en),
        .wr_data    (cpu_wr_data),
        .shadow_q   (shadow_q),
        .shadow_nxt (shadow_nxt)
    );

    mux_sel_lock_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .adc_en     (adc_en),
        .conv_start (conv_start),
        .conv_last  (conv_last),
        .capture    (capture),
        .locked     (lock_active)
    );

    mux_sel_eff_reg #(.CH_W(CH_W), .REF_W(REF_W)) u_eff (
        .clk    (clk),
        .rst    (rst),
        .load   (capture),
        .sel_in (shadow_nxt),
        .chan_q (eff_chan),
        .ref_q  (eff_ref)
    );

    assign rd_data = shadow_q;

endmodule

// File: rtl/mux_sel_lock_chk.sv
module mux_sel_lock_chk #(
    parameter int CH_W  = 5,
    parameter int REF_W = 2,
    localparam int SEL_W = CH_W + REF_W
) (
    input logic             clk,
    input logic             rst,
    input logic             adc_en,
    input logic             cpu_wr_en,
    input logic [SEL_W-1:0] cpu_wr_data,
    input logic             conv_start,
    input logic             conv_last,
    input logic [SEL_W-1:0] rd_data,
    input logic [CH_W-1:0]  eff_chan,
    input logic [REF_W-1:0] eff_ref,
    input logic             locked
);

    logic [SEL_W-1:0] eff_sel;
    assign eff_sel = {eff_ref, eff_chan};

    // R1: a write is seen on the readback after its edge
    a_r1_readback: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_en |=> rd_data == $past(cpu_wr_data));

    // R2: tracking keeps the effective copy equal to the shadow
    a_r2_track: assert property (@(posedge clk) disable iff (rst)
        (adc_en && !locked) |=> eff_sel == rd_data);

    // R3: an enabled start engages the lock
    a_r3_start_locks: assert property (@(posedge clk) disable iff (rst)
        (adc_en && conv_start) |=> locked);

    // R4: while held, the effective copy does not move
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (adc_en && locked && !conv_start && !conv_last) |=> $stable(eff_sel));

    // R5: the last-cycle pulse releases the lock
    a_r5_reopen: assert property (@(posedge clk) disable iff (rst)
        (adc_en && conv_last && !conv_start) |=> (!locked && eff_sel == rd_data));

    // R7: disable drops the lock and keeps tracking
    a_r7_disable: assert property (@(posedge clk) disable iff (rst)
        !adc_en |=> (!locked && eff_sel == rd_data));

    // R9: reset state
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (!locked && rd_data == '0 && eff_sel == '0));

endmodule

bind mux_sel_lock mux_sel_lock_chk #(.CH_W(CH_W), .REF_W(REF_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_en      (adc_en),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .conv_start  (conv_start),
    .conv_last   (conv_last),
    .rd_data     (rd_data),
    .eff_chan    (eff_chan),
    .eff_ref     (eff_ref),
    .locked      (lock_active)
);

// File: tb/test_mux_sel_lock.sv
module test_mux_sel_lock;

    localparam int CH_W  = 5;
    localparam int REF_W = 2;
    localparam int SEL_W = CH_W + REF_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             adc_en;
    logic             cpu_wr_en;
    logic [SEL_W-1:0] cpu_wr_data;
    logic             conv_start;
    logic             conv_last;
    logic [SEL_W-1:0] rd_data;
    logic [CH_W-1:0]  eff_chan;
    logic [REF_W-1:0] eff_ref;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mux_sel_lock #(.CH_W(CH_W), .REF_W(REF_W)) i_mux_sel_lock (
        .clk         (clk),
        .rst         (rst),
        .adc_en      (adc_en),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_data (cpu_wr_data),
        .conv_start  (conv_start),
        .conv_last   (conv_last),
        .rd_data     (rd_data),
        .eff_chan    (eff_chan),
        .eff_ref     (eff_ref)
    );

    function automatic logic [SEL_W-1:0] pk(input int r, input int c);
        return {REF_W'(r), CH_W'(c)};
    endfunction

    task automatic chk(input string tag, input logic [SEL_W-1:0] act,
                       input logic [SEL_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle with the given stimulus; pulses drop afterwards.
    task automatic step(input logic wr, input logic [SEL_W-1:0] d,
                        input logic st, input logic ls);
        cpu_wr_en   = wr;
        cpu_wr_data = d;
        conv_start  = st;
        conv_last   = ls;
        @(posedge clk);
        @(negedge clk);
        cpu_wr_en  = 1'b0;
        conv_start = 1'b0;
        conv_last  = 1'b0;
    endtask

    function automatic logic [SEL_W-1:0] eff();
        return {eff_ref, eff_chan};
    endfunction

    task automatic t_reset();
        rst = 1'b1; adc_en = 1'b0;
        step(1'b0, '0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        rst = 1'b0;
        chk("R9 readback after reset", rd_data, '0);
        chk("R9 effective after reset", eff(), '0);
        adc_en = 1'b1;
        step(1'b1, pk(1, 4), 1'b0, 1'b0);
        chk("R9 not locked after reset", eff(), pk(1, 4));
    endtask

    task automatic t_track();
        step(1'b1, pk(2, 31), 1'b0, 1'b0);
        chk("R1 field packing", rd_data, 7'b10_11111);
        chk("R2 follows same edge", eff(), pk(2, 31));
        step(1'b1, pk(1, 6), 1'b0, 1'b0);
        chk("R2 follows second write", eff(), pk(1, 6));
    endtask

    task automatic t_lock();
        step(1'b1, pk(0, 3), 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R3 captured at start", eff(), pk(0, 3));
        step(1'b1, pk(3, 9), 1'b0, 1'b0);
        chk("R1 readback during lock", rd_data, pk(3, 9));
        chk("R4 held after write", eff(), pk(0, 3));
        step(1'b0, '0, 1'b0, 1'b0);
        chk("R4 still held", eff(), pk(0, 3));
        step(1'b0, '0, 1'b0, 1'b1);
        chk("R5 reopen loads shadow", eff(), pk(3, 9));
        step(1'b1, pk(1, 12), 1'b0, 1'b0);
        chk("R5 tracking resumed", eff(), pk(1, 12));
    endtask

    task automatic t_start_write();
        step(1'b1, pk(2, 17), 1'b1, 1'b0);
        chk("R3 same-cycle write captured", eff(), pk(2, 17));
        step(1'b1, pk(0, 1), 1'b0, 1'b1);
        chk("R5 same-cycle write at reopen", eff(), pk(0, 1));
    endtask

    task automatic t_free_run();
        step(1'b1, pk(0, 1), 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b1, 1'b0);
        chk("R6 restart keeps value", eff(), pk(0, 1));
        step(1'b1, pk(0, 2), 1'b0, 1'b0);
        chk("R6 write after restart held", eff(), pk(0, 1));
        step(1'b0, '0, 1'b0, 1'b0);
        chk("R6 still held", eff(), pk(0, 1));
        step(1'b0, '0, 1'b0, 1'b1);
        chk("R6 applied at next reopen", eff(), pk(0, 2));
    endtask

    task automatic t_both();
        step(1'b0, '0, 1'b1, 1'b1);
        step(1'b1, pk(3, 20), 1'b0, 1'b0);
        chk("R8 start wins over last", eff(), pk(0, 2));
        step(1'b0, '0, 1'b0, 1'b1);
        chk("R8 released by later last", eff(), pk(3, 20));
    endtask

    task automatic t_disable();
        step(1'b0, '0, 1'b1, 1'b0);
        adc_en = 1'b0;
        step(1'b1, pk(1, 7), 1'b0, 1'b0);
        chk("R7 disable releases lock", eff(), pk(1, 7));
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, pk(2, 8), 1'b0, 1'b0);
        chk("R7 start ignored when off", eff(), pk(2, 8));
        adc_en = 1'b1;
        step(1'b1, pk(0, 5), 1'b0, 1'b0);
        chk("R7 tracking after enable", eff(), pk(0, 5));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cpu_wr_en = 1'b0; cpu_wr_data = '0;
        conv_start = 1'b0; conv_last = 1'b0;
        rst = 1'b1; adc_en = 1'b0;
        @(negedge clk);
        t_reset();
        t_track();
        t_lock();
        t_start_write();
        t_free_run();
        t_both();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule